// File: doc/BRIEF.md
# Filtered Quadrature Decoder

This block turns the raw A and B signals of one incremental encoder axis into a count-enable pulse and a direction bit for a downstream 24-bit position counter. Both inputs are first brought into the block clock domain by a short synchronizer. In the quadrature modes, a programmable prescaler derives a sampling tick from the block clock. A per-channel digital filter samples each input on that tick and only takes a new level once it has seen that level on several samples in a row. The decoder works from these validated levels and counts once per full cycle (x1), twice per cycle (x2) or on every edge (x4).

A direct mode bypasses the prescaler and the filter. In this mode, the synchronized A acts as the count clock and B gives the direction. A sticky error flag records any filter sample in which both validated channels change together, which means the encoder moved faster than the filter can resolve. An optional gate input can hold off all counting. Encoder movement that happens while the gate is closed is absorbed and is not counted later.

Top module: `quad_filter_decoder`

## Requirements
- R1: With `mode_sel` = 2'b11 (x4), every accepted single-channel change of the validated A/B pair gives exactly one `cnt_en` pulse of one cycle, so a full encoder cycle gives four pulses.
- R2: With `mode_sel` = 2'b10 (x2), only accepted changes of A give a pulse, so a full cycle gives two.
- R3: With `mode_sel` = 2'b01 (x1), only an accepted rising edge of A gives a pulse, so a full cycle gives one, in either direction.
- R4: In the quadrature modes, `cnt_up` is 1 with each pulse when A leads B, which is the state order (A,B) = 00, 10, 11, 01. It is 0 for the reverse order. `cnt_up` is never 1 without `cnt_en`.
- R5: In the quadrature modes the filter samples once every `psc_div`+1 clock cycles.
- R6: A filtered input takes a new level only after 3 consecutive samples show that level. A level held for exactly 3·(`psc_div`+1) cycles is accepted. A level held for exactly 2·(`psc_div`+1) cycles is discarded, with no pulse and no error.
- R7: If both validated channels change on the same sample, no pulse is produced and `err_flag` is set.
- R8: `err_flag` stays set until `err_clr` is driven high for a cycle, which clears it.
- R9: With `mode_sel` = 2'b00 (direct), every rising edge of the synchronized A gives one pulse, and `cnt_up` equals B. No filtering takes place, so pulses only two cycles wide are counted whatever the `psc_div` value.
- R10: With `gate_sel` = 1, no pulses are produced while `gate_in` is low. Movement made during that time is never counted. With `gate_sel` = 0, `gate_in` has no effect.
- R11: After reset, `cnt_en`, `cnt_up` and `err_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the reference for the filter prescaler |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | 00 direct, 01 x1, 10 x2, 11 x4 |
| psc_div | input | PSC_W | Prescaler value n; filter samples every n+1 cycles |
| gate_sel | input | 1 | 1 makes `gate_in` act as an A/B enable |
| gate_in | input | 1 | Enable gate, high = counting allowed |
| a_in | input | 1 | Raw encoder channel A |
| b_in | input | 1 | Raw encoder channel B |
| err_clr | input | 1 | Clears the sticky error flag |
| cnt_en | output | 1 | One-cycle count-enable pulse |
| cnt_up | output | 1 | Direction of the current pulse, 1 = up |
| err_flag | output | 1 | Sticky too-fast-input flag |

## Verification
The bench drives whole forward and reverse encoder cycles in each of the three quadrature modes over several prescaler settings. It compares the pulse total and the up-pulse total with the arithmetic product of cycles and counts per cycle, which separates the x1, x2 and x4 selections and shows whether the direction is right. Single-channel pulses exactly two and exactly three sample periods wide, swept over the prescaler values, find the acceptance threshold of the filter and so show whether the divide ratio is right. Simultaneous changes on both channels, gated movement, and narrow direct-mode pulses with a large prescaler setting separate the error path, the gate absorption and the filter bypass.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
   typedef enum logic [1:0] {
      QM_DIRECT = 2'b00,
      QM_X1     = 2'b01,
      QM_X2     = 2'b10,
      QM_X4     = 2'b11
   } qmode_e;
endpackage

// File: rtl/qdec_prescaler.sv
module qdec_prescaler #(
   parameter int PSC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [PSC_W-1:0] div,
   output logic             tick
);
   logic [PSC_W-1:0] cnt_q;
   logic             wrap;

   assign wrap = (cnt_q >= div);
   assign tick = run & wrap;

   always_ff @(posedge clk) begin
      if (!rst_n)        cnt_q <= '0;
      else if (!run)     cnt_q <= '0;
      else if (wrap)     cnt_q <= '0;
      else               cnt_q <= cnt_q + 1'b1;
   end

   // R5: a nonzero divider never yields back-to-back ticks
   p_tick_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && div != '0 && $stable(div)) |=> (!tick || div == '0));
endmodule

// File: rtl/qdec_glitch_filter.sv
module qdec_glitch_filter #(
   parameter int DEPTH = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic din,
   output logic dout
);
   logic [DEPTH-2:0] hist_q;
   logic [DEPTH-1:0] window;
   logic             lvl_q;

   assign window = {hist_q, din};
   assign dout   = lvl_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hist_q <= '0;
         lvl_q  <= 1'b0;
      end else if (tick) begin
         hist_q <= window[DEPTH-2:0];
         if (&window)       lvl_q <= 1'b1;
         else if (~|window) lvl_q <= 1'b0;
      end
   end

   // R6: the validated level only moves on a sample tick
   p_hold_between_ticks_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(lvl_q));
endmodule

// File: rtl/qdec_decoder.sv
module qdec_decoder
   import qdec_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  qmode_e mode,
   input  logic   gate_ok,
   input  logic   fa,
   input  logic   fb,
   input  logic   ra,
   input  logic   rb,
   input  logic   err_clr,
   output logic   cnt_en,
   output logic   cnt_up,
   output logic   err_flag
);
   logic pa_q, pb_q, ra_q;
   logic da, db, illegal, quad_up, hit, up_n;
   logic en_q, up_q, err_q;

   assign da      = fa ^ pa_q;
   assign db      = fb ^ pb_q;
   assign illegal = da & db;
   assign quad_up = ~(pa_q ^ fb);

   always_comb begin
      unique case (mode)
         QM_X4:   hit = da ^ db;
         QM_X2:   hit = da & ~db;
         QM_X1:   hit = da & ~db & fa;
         default: hit = ra & ~ra_q;
      endcase
      up_n = (mode == QM_DIRECT) ? rb : quad_up;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pa_q  <= 1'b0;
         pb_q  <= 1'b0;
         ra_q  <= 1'b0;
         en_q  <= 1'b0;
         up_q  <= 1'b0;
         err_q <= 1'b0;
      end else begin
         pa_q <= fa;
         pb_q <= fb;
         ra_q <= ra;
         en_q <= gate_ok & hit;
         up_q <= gate_ok & hit & up_n;
         if (mode != QM_DIRECT && gate_ok && illegal) err_q <= 1'b1;
         else if (err_clr)                            err_q <= 1'b0;
      end
   end

   assign cnt_en   = en_q;
   assign cnt_up   = up_q;
   assign err_flag = err_q;

   // R7: a double change is never counted
   p_illegal_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != QM_DIRECT && gate_ok && da && db) |=> (!cnt_en && err_flag));
   // R8: flag holds until cleared
   p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (err_flag && !err_clr) |=> err_flag);
   // R10: closed gate suppresses the next pulse
   p_gate_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !gate_ok |=> !cnt_en);
   // R4: direction only qualifies a pulse
   p_up_with_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_up |-> cnt_en);
endmodule

// File: rtl/quad_filter_decoder.sv
module quad_filter_decoder
   import qdec_pkg::*;
#(
   parameter int PSC_W       = 8,
   parameter int FILT_DEPTH  = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       mode_sel,
   input  logic [PSC_W-1:0] psc_div,
   input  logic             gate_sel,
   input  logic             gate_in,
   input  logic             a_in,
   input  logic             b_in,
   input  logic             err_clr,
   output logic             cnt_en,
   output logic             cnt_up,
   output logic             err_flag
);
   localparam int NCH = 3;

   if (PSC_W < 1 || PSC_W > 16) begin : g_bad_psc_w
      $error("PSC_W must lie in 1..16");
   end
   if (FILT_DEPTH < 2) begin : g_bad_depth
      $error("FILT_DEPTH must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   qmode_e mode;
   assign mode = qmode_e'(mode_sel);

   logic [SYNC_STAGES-1:0][NCH-1:0] sync_q;
   logic [NCH-1:0]                  sync_out;

   always_ff @(posedge clk) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], {gate_in, b_in, a_in}};
   end
   assign sync_out = sync_q[SYNC_STAGES-1];

   logic tick, run, gate_ok;
   logic [1:0] filt_ab;

   assign run     = (mode != QM_DIRECT);
   assign gate_ok = ~gate_sel | sync_out[2];

   qdec_prescaler #(.PSC_W(PSC_W)) u_psc (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (run),
      .div  (psc_div),
      .tick (tick)
   );

   for (genvar ch = 0; ch < 2; ch++) begin : g_chan
      qdec_glitch_filter #(.DEPTH(FILT_DEPTH)) u_filt (
         .clk  (clk),
         .rst_n(rst_n),
         .tick (tick),
         .din  (sync_out[ch]),
         .dout (filt_ab[ch])
      );
   end

   qdec_decoder u_dec (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode    (mode),
      .gate_ok (gate_ok),
      .fa      (filt_ab[0]),
      .fb      (filt_ab[1]),
      .ra      (sync_out[0]),
      .rb      (sync_out[1]),
      .err_clr (err_clr),
      .cnt_en  (cnt_en),
      .cnt_up  (cnt_up),
      .err_flag(err_flag)
   );

   // R9: in direct mode the filter never samples
   p_direct_no_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == QM_DIRECT) |-> !tick);
endmodule

// File: tb/test_quad_filter_decoder.sv
module test_quad_filter_decoder;
   logic       clk = 1'b0;
   logic       rst_n;
   logic [1:0] mode_sel;
   logic [7:0] psc_div;
   logic       gate_sel, gate_in, a_in, b_in, err_clr;
   logic       cnt_en, cnt_up, err_flag;

   int n_run = 0, n_fail = 0, n_pulse = 0, n_up = 0, step = 20;
   bit done = 0;

   always #5 clk = ~clk;

   quad_filter_decoder i_quad_filter_decoder (
      .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .psc_div(psc_div),
      .gate_sel(gate_sel), .gate_in(gate_in), .a_in(a_in), .b_in(b_in),
      .err_clr(err_clr), .cnt_en(cnt_en), .cnt_up(cnt_up), .err_flag(err_flag)
   );

   always @(negedge clk) if (rst_n && cnt_en) begin
      n_pulse++;
      if (cnt_up) n_up++;
   end

   task automatic check(string tag, int act, int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic hold(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_ab(bit a, bit b);
      @(negedge clk);
      a_in = a; b_in = b;
      hold(step);
   endtask

   task automatic run_cycle(bit up);
      if (up) begin set_ab(1,0); set_ab(1,1); set_ab(0,1); set_ab(0,0); end
      else    begin set_ab(0,1); set_ab(1,1); set_ab(1,0); set_ab(0,0); end
   endtask

   task automatic set_psc(int v);
      psc_div = 8'(v);
      step = 4 * (v + 1) + 10;
      hold(20);
   endtask

   initial begin
      rst_n = 0; mode_sel = 2'b11; psc_div = 0; gate_sel = 0; gate_in = 0;
      a_in = 0; b_in = 0; err_clr = 0;
      hold(5);
      check("R11 cnt_en after reset", int'(cnt_en), 0);
      check("R11 cnt_up after reset", int'(cnt_up), 0);
      check("R11 err_flag after reset", int'(err_flag), 0);
      @(negedge clk); rst_n = 1;
      hold(5);

      // R1 R2 R3 R4: count-per-cycle and direction sweep
      for (int m = 1; m <= 3; m++) begin
         for (int pi = 0; pi < 4; pi++) begin
            int per, p0, u0;
            mode_sel = 2'(m);
            set_psc(pi == 0 ? 0 : (pi == 1 ? 1 : (pi == 2 ? 3 : 6)));
            per = (m == 3) ? 4 : ((m == 2) ? 2 : 1);
            for (int d = 0; d < 2; d++) begin
               p0 = n_pulse; u0 = n_up;
               repeat (3) run_cycle(d[0]);
               hold(10);
               check(m == 3 ? "R1 x4 pulses" : (m == 2 ? "R2 x2 pulses" : "R3 x1 pulses"),
                     n_pulse - p0, 3 * per);
               check("R4 up pulses", n_up - u0, d == 1 ? 3 * per : 0);
            end
         end
      end

      // R5 R6: acceptance threshold follows the prescaler
      mode_sel = 2'b11;
      for (int pi = 0; pi < 4; pi++) begin
         int pv, pp, p0, u0;
         pv = (pi == 0) ? 0 : ((pi == 1) ? 2 : ((pi == 2) ? 4 : 9));
         set_psc(pv);
         pp = pv + 1;
         p0 = n_pulse;
         @(negedge clk); a_in = 1; hold(2 * pp); a_in = 0; hold(step);
         check("R6 short level rejected", n_pulse - p0, 0);
         check("R6 no error on glitch", int'(err_flag), 0);
         p0 = n_pulse; u0 = n_up;
         @(negedge clk); a_in = 1; hold(3 * pp); a_in = 0; hold(step);
         check("R5 three-sample level accepted", n_pulse - p0, 2);
         check("R5 accepted pulse direction", n_up - u0, 1);
      end

      // R7 R8: simultaneous change
      begin
         int p0;
         set_psc(1);
         p0 = n_pulse;
         set_ab(1,1);
         check("R7 double change not counted", n_pulse - p0, 0);
         check("R7 error set", int'(err_flag), 1);
         hold(50);
         check("R8 error sticky", int'(err_flag), 1);
         @(negedge clk); err_clr = 1; @(negedge clk); err_clr = 0; hold(2);
         check("R8 error cleared", int'(err_flag), 0);
         set_ab(0,0);
         check("R7 second double change", int'(err_flag), 1);
         check("R7 no pulse on return", n_pulse - p0, 0);
         @(negedge clk); err_clr = 1; @(negedge clk); err_clr = 0; hold(2);
         check("R8 error cleared again", int'(err_flag), 0);
      end

      // R10: gate absorbs movement
      begin
         int p0, u0;
         gate_sel = 1; gate_in = 0; hold(10);
         p0 = n_pulse;
         set_ab(1,0); set_ab(1,1);
         check("R10 gated movement silent", n_pulse - p0, 0);
         @(negedge clk); gate_in = 1; hold(step);
         check("R10 no late count on reopen", n_pulse - p0, 0);
         p0 = n_pulse; u0 = n_up;
         set_ab(0,1); set_ab(0,0);
         check("R10 counting resumes", n_pulse - p0, 2);
         check("R10 resumed direction", n_up - u0, 2);
         @(negedge clk); gate_sel = 0; gate_in = 0; hold(10);
         p0 = n_pulse;
         run_cycle(1);
         check("R10 gate ignored when unselected", n_pulse - p0, 4);
         check("R10 no error from gating", int'(err_flag), 0);
      end

      // R9: direct mode, no filter
      begin
         int p0, u0;
         mode_sel = 2'b00; psc_div = 8'd255; hold(10);
         @(negedge clk); b_in = 1; hold(4);
         p0 = n_pulse; u0 = n_up;
         repeat (5) begin @(negedge clk); a_in = 1; hold(2); a_in = 0; hold(2); end
         hold(10);
         check("R9 direct pulses up", n_pulse - p0, 5);
         check("R9 direct up count", n_up - u0, 5);
         @(negedge clk); b_in = 0; hold(4);
         p0 = n_pulse; u0 = n_up;
         repeat (4) begin @(negedge clk); a_in = 1; hold(2); a_in = 0; hold(2); end
         hold(10);
         check("R9 direct pulses down", n_pulse - p0, 4);
         check("R9 direct down count", n_up - u0, 0);
         gate_sel = 1; gate_in = 0; hold(4);
         p0 = n_pulse;
         repeat (3) begin @(negedge clk); a_in = 1; hold(2); a_in = 0; hold(2); end
         hold(10);
         check("R10 direct gated", n_pulse - p0, 0);
         gate_in = 1; hold(4);
         p0 = n_pulse;
         repeat (2) begin @(negedge clk); a_in = 1; hold(2); a_in = 0; hold(2); end
         hold(10);
         check("R9 direct after gate opens", n_pulse - p0, 2);
      end

      if (!done) begin
         done = 1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      #(10 * 200000);
      if (!done) begin
         done = 1;
         n_run++; n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule